// File: doc/BRIEF.md
# ODT Timing Mode Selector

This block sits in a DRAM controller next to the command scheduler. Each cycle it decides whether the next on-die-termination edge must follow the synchronous turn-on/turn-off latencies or the asynchronous power-down windows. It then drives the termination-enable pin and a registered mode flag that stays aligned with that pin.

The scheduler presents the clock-enable level it has committed to, three cycles ahead of the cycle in which the device latches it. It also supplies whether any row is open, the slow-exit setting from the mode register, a self-refresh flag and the requested termination level. Inside the block, a short pipeline of the committed clock-enable values looks ahead to power-down entry. A saturating counter measures the time since power-down exit. Together they mark every cycle in which an edge would fall too close to a clock-enable transition for synchronous timing.

A request to change termination during self-refresh is refused. The pin holds its level and a one-cycle reject flag is raised.

Top module: `odt_mode_sel`

## Requirements
- R1: While `rstN` is low, `odtPin`, `asyncMode` and `odtReject` are all 0.
- R2: In a cycle sampled with `selfRefresh` low, `odtPin` takes the value of `odtReq` at that clock edge.
- R3: The device-latched clock enable equals `ckeCmd` as sampled three edges earlier, and is 1 after reset. When latched high with no R6 or R7 window open, `asyncMode` becomes 0 (synchronous).
- R4: When latched low with `rowOpen`=1 and `slowExit`=0 (fast-exit active power-down), `asyncMode` becomes 0.
- R5: When latched low with `slowExit`=1 or `rowOpen`=0 (slow-exit or precharge power-down), `asyncMode` becomes 1.
- R6: When latched high but `ckeCmd` is 0 at the current edge or at either of the two edges before it, `asyncMode` becomes 1 (power-down entry is at most three cycles away).
- R7: When latched high and the latched value was low at any of the eight edges before the current one, `asyncMode` becomes 1. From the ninth consecutive latched-high edge on, R3 applies. Each new low resets this window.
- R8: In a cycle sampled with `selfRefresh` high, `odtPin` keeps its previous value regardless of `odtReq`.
- R9: `odtReject` is 1 for exactly the cycle after an edge at which `selfRefresh` is 1 and `odtReq` differs from the current `odtPin`. At every other time it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rstN | input | 1 | Asynchronous active-low reset |
| ckeCmd | input | 1 | Clock-enable level committed by the scheduler, three cycles ahead of the device latch |
| rowOpen | input | 1 | 1 when any row of any bank is open |
| slowExit | input | 1 | Slow-exit power-down setting from the mode register |
| selfRefresh | input | 1 | 1 while the device is in self-refresh |
| odtReq | input | 1 | Requested termination level |
| odtPin | output | 1 | Registered termination-enable pin |
| asyncMode | output | 1 | Registered timing class: 0 synchronous, 1 asynchronous |
| odtReject | output | 1 | One-cycle flag for a refused change during self-refresh |

## Verification
The assertions check several properties on every cycle:
- the pin follows the request outside self-refresh and holds inside it;
- the reject flag appears only after a refused change;
- each power-down flavour maps to its timing class;
- a committed low always opens the entry window;
- a latched rising edge always opens the exit window.

Only the bench's sweeps show the exact width of both windows. The sweeps cover low bursts of every length from one to twelve cycles and high gaps shorter and longer than the exit window, so they show where the windows close and how a fresh low restarts the exit count. The sweeps also cover the interaction of all four row-open and slow-exit combinations.

// File: rtl/odt_sel_pkg.sv
package odt_sel_pkg;

  // Strobes from the window control to the mode datapath
  typedef struct packed {
    logic ckeLatched;   // clock enable as the device has latched it
    logic entryWin;     // a committed low is within the entry lookahead
    logic exitWin;      // latched high, but exit was too recent
  } winStrobe_t;

  typedef enum logic {
    MODE_SYNC  = 1'b0,
    MODE_ASYNC = 1'b1
  } odtMode_e;

endpackage

// File: rtl/odt_sel_window.sv
module odt_sel_window
  import odt_sel_pkg::*;
#(
  parameter int ENTRY_LEAD = 3,
  parameter int EXIT_WIN   = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       ckeCmd,
  output winStrobe_t strobe
);

  localparam int LAST  = ENTRY_LEAD - 1;
  localparam int CNT_W = $clog2(EXIT_WIN + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(EXIT_WIN);

  logic [ENTRY_LEAD-1:0] ckePipe;
  logic [CNT_W-1:0]      exitCnt;
  logic                  pendingLow;

  // Delay line from the committed level to the device-latched level
  for (genvar g = 0; g < ENTRY_LEAD; g++) begin : gStage
    if (g == 0) begin : gHead
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) ckePipe[0] <= 1'b1;
        else       ckePipe[0] <= ckeCmd;
      end
    end else begin : gBody
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) ckePipe[g] <= 1'b1;
        else       ckePipe[g] <= ckePipe[g-1];
      end
    end
  end

  // Any committed low that has not reached the latch yet
  always_comb begin
    pendingLow = !ckeCmd;
    for (int i = 0; i < LAST; i++) begin
      if (!ckePipe[i]) pendingLow = 1'b1;
    end
  end

  // Run length of latched-high cycles, saturating at the window size
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  exitCnt <= CNT_MAX;
    else if (!ckePipe[LAST])    exitCnt <= '0;
    else if (exitCnt < CNT_MAX) exitCnt <= exitCnt + 1'b1;
  end

  always_comb begin
    strobe.ckeLatched = ckePipe[LAST];
    strobe.entryWin   = ckePipe[LAST] && pendingLow;
    strobe.exitWin    = ckePipe[LAST] && (exitCnt < CNT_MAX);
  end

  AST_ENTRY_OPENS: assert property (@(posedge clk) disable iff (!rstN)
    !ckeCmd |=> (!strobe.ckeLatched || strobe.entryWin)); // R6

  AST_EXIT_OPENS: assert property (@(posedge clk) disable iff (!rstN)
    $rose(strobe.ckeLatched) |-> strobe.exitWin); // R7

  AST_LATCH_DELAY: assert property (@(posedge clk) disable iff (!rstN)
    (!ckeCmd && $past(!ckeCmd) && $past(!ckeCmd, 2)) |=> !strobe.entryWin); // R3

endmodule

// File: rtl/odt_sel_path.sv
module odt_sel_path
  import odt_sel_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  winStrobe_t strobe,
  input  logic       rowOpen,
  input  logic       slowExit,
  input  logic       selfRefresh,
  input  logic       odtReq,
  output logic       odtPin,
  output logic       asyncMode,
  output logic       odtReject
);

  odtMode_e modeNext;
  logic     wantChange;

  always_comb begin
    if (!strobe.ckeLatched) begin
      modeNext = (slowExit || !rowOpen) ? MODE_ASYNC : MODE_SYNC;
    end else if (strobe.entryWin || strobe.exitWin) begin
      modeNext = MODE_ASYNC;
    end else begin
      modeNext = MODE_SYNC;
    end
  end

  assign wantChange = (odtReq != odtPin);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      odtPin    <= 1'b0;
      asyncMode <= 1'b0;
      odtReject <= 1'b0;
    end else begin
      asyncMode <= modeNext;
      odtReject <= selfRefresh && wantChange;
      if (!selfRefresh) odtPin <= odtReq;
    end
  end

  AST_FOLLOW_REQ: assert property (@(posedge clk) disable iff (!rstN)
    !selfRefresh |=> (odtPin == $past(odtReq))); // R2

  AST_SR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    selfRefresh |=> $stable(odtPin)); // R8

  AST_REJECT_RAISE: assert property (@(posedge clk) disable iff (!rstN)
    (selfRefresh && (odtReq != odtPin)) |=> odtReject); // R9

  AST_REJECT_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !selfRefresh |=> !odtReject); // R9

  AST_FAST_PD_SYNC: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.ckeLatched && rowOpen && !slowExit) |=> !asyncMode); // R4

  AST_SLOW_PD_ASYNC: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.ckeLatched && (slowExit || !rowOpen)) |=> asyncMode); // R5

endmodule

// File: rtl/odt_mode_sel.sv
module odt_mode_sel
  import odt_sel_pkg::*;
#(
  parameter int ENTRY_LEAD = 3,
  parameter int EXIT_WIN   = 8
) (
  input  logic clk,
  input  logic rstN,
  input  logic ckeCmd,
  input  logic rowOpen,
  input  logic slowExit,
  input  logic selfRefresh,
  input  logic odtReq,
  output logic odtPin,
  output logic asyncMode,
  output logic odtReject
);

  winStrobe_t winStrobe;

  odt_sel_window #(
    .ENTRY_LEAD (ENTRY_LEAD),
    .EXIT_WIN   (EXIT_WIN)
  ) u_window (
    .clk    (clk),
    .rstN   (rstN),
    .ckeCmd (ckeCmd),
    .strobe (winStrobe)
  );

  odt_sel_path u_path (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (winStrobe),
    .rowOpen     (rowOpen),
    .slowExit    (slowExit),
    .selfRefresh (selfRefresh),
    .odtReq      (odtReq),
    .odtPin      (odtPin),
    .asyncMode   (asyncMode),
    .odtReject   (odtReject)
  );

endmodule

// File: tb/odt_mode_sel_tb.sv
`timescale 1ns/1ps
module odt_mode_sel_tb;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ckeCmd = 1'b1, rowOpen = 1'b0, slowExit = 1'b0;
  logic selfRefresh = 1'b0, odtReq = 1'b0;
  logic odtPin, asyncMode, odtReject;

  int nChk = 0;
  int nErr = 0;
  bit finished = 1'b0;

  // Reference state: committed levels 1..11 edges back, previous pin
  logic hist [0:10];
  logic prevOdt;
  logic [15:0] lfsr = 16'hACE1;

  always #4 clk = ~clk;

  odt_mode_sel u_dut (
    .clk(clk), .rstN(rstN), .ckeCmd(ckeCmd), .rowOpen(rowOpen),
    .slowExit(slowExit), .selfRefresh(selfRefresh), .odtReq(odtReq),
    .odtPin(odtPin), .asyncMode(asyncMode), .odtReject(odtReject)
  );

  task automatic chk(input string tag, input string what, input logic act, input logic exp);
    nChk++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s %s actual=%0b expected=%0b at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic logic nextRand();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    return lfsr[0];
  endfunction

  // One cycle: drive at negedge, predict, let the edge pass, compare
  task automatic step(input logic c, input logic row, input logic slow,
                      input logic sr, input logic req);
    logic eMode, eOdt, eRej, lat, early, late;
    string mTag, oTag;
    ckeCmd = c; rowOpen = row; slowExit = slow; selfRefresh = sr; odtReq = req;
    lat   = hist[2];
    early = !c || !hist[0] || !hist[1];
    late  = 1'b0;
    for (int i = 3; i <= 10; i++) if (!hist[i]) late = 1'b1;
    if (!lat) begin
      eMode = !row || slow;
      mTag  = eMode ? "R5" : "R4";
    end else if (early) begin
      eMode = 1'b1; mTag = "R6";
    end else if (late) begin
      eMode = 1'b1; mTag = "R7";
    end else begin
      eMode = 1'b0; mTag = "R3";
    end
    eOdt = sr ? prevOdt : req;
    oTag = sr ? "R8" : "R2";
    eRej = sr && (req != prevOdt);
    prevOdt = eOdt;
    for (int i = 10; i > 0; i--) hist[i] = hist[i-1];
    hist[0] = c;
    @(posedge clk);
    @(negedge clk);
    chk(mTag, "asyncMode", asyncMode, eMode);
    chk(oTag, "odtPin", odtPin, eOdt);
    chk("R9", "odtReject", odtReject, eRej);
  endtask

  initial begin
    for (int i = 0; i <= 10; i++) hist[i] = 1'b1;
    prevOdt = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1", "odtPin in reset", odtPin, 1'b0);
    chk("R1", "asyncMode in reset", asyncMode, 1'b0);
    chk("R1", "odtReject in reset", odtReject, 1'b0);
    rstN = 1'b1;

    // Settled synchronous operation with toggling requests (R2, R3)
    for (int k = 0; k < 16; k++) step(1'b1, 1'b1, 1'b0, 1'b0, k[0]);

    // Sweep: every low-burst length, each power-down flavour, three gaps
    for (int lowLen = 1; lowLen <= 12; lowLen++) begin
      for (int cfg = 0; cfg < 4; cfg++) begin
        for (int g = 0; g < 3; g++) begin
          int gap;
          gap = (g == 0) ? 1 : ((g == 1) ? 5 : 14);
          for (int k = 0; k < lowLen; k++)
            step(1'b0, cfg[0], cfg[1], (lfsr[3:0] == 4'd0), nextRand());
          for (int k = 0; k < gap; k++)
            step(1'b1, cfg[0], cfg[1], (lfsr[3:0] == 4'd0), nextRand());
        end
      end
    end

    // Self-refresh with requests that both match and differ (R8, R9)
    for (int k = 0; k < 12; k++) step(1'b0, 1'b0, 1'b0, 1'b1, k[1]);
    for (int k = 0; k < 16; k++) step(1'b1, 1'b0, 1'b0, 1'b0, k[0]);

    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nErr);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nChk++;
      nErr++;
      $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nErr);
      $finish;
    end
  end

endmodule